// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit watches a vector of sampled pad inputs and raises a single interrupt request when an enabled and unmasked pin records an event. The pins form two equal groups. Each group has one control bit that picks edge or level sensing and one that picks the polarity. A pin whose direction bit marks it as an output is ignored. Detected events latch into a pending vector that software clears by writing ones to it.

Software reaches the unit through a single-cycle register port. A transfer is `acc_valid` high for one clock. A write takes effect at that clock edge. Read data and the error flag are combinational during the transfer cycle. The final mask vector is protected: only transfers with `acc_nonsec` low may change it or read it, and it resets to fully masked.

Top module: `gpio_irq_detect`

## Requirements
- R1: Control register (address 0, 4 bits, upper read bits zero). Bit 0 and bit 1 select the sensing type for group 0 (pins 15:0) and group 1 (pins 31:16); 1 means edge and 0 means level. Bit 2 and bit 3 set the polarity for group 0 and group 1; 1 means rising or active-high, and 0 means falling or active-low.
- R2: In edge mode a pin raises an event when its current sample differs from the sample of the previous cycle in the selected direction. The previous-sample register resets to zero.
- R3: In level mode a pin raises an event on every cycle it sits at its active level, so a clear cannot hold while that level lasts.
- R4: A pin whose direction bit (address 1) is 1 never sets its pending bit.
- R5: A write to the pending register (address 4) clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R6: When an event and a write-1 clear hit the same pending bit in the same cycle, the clear wins and the bit reads 0 afterwards.
- R7: `irq` is high exactly when some pin has pending, enable (address 2) and not mask (address 3) all set.
- R8: After reset the mask reads all ones, and control, direction, enable and pending read zero.
- R9: A mask write with `acc_nonsec` high is dropped and flags an error. A mask read with `acc_nonsec` high returns zero and flags an error.
- R10: An access to addresses 5 to 7 flags an error, reads zero and changes no register.
- R11: `acc_err` is high only in the cycle of a rejected transfer.
- R12: Read data is the addressed register during a read cycle and zero otherwise. A write becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register transfer in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_nonsec | input | 1 | 1 = non-secure transfer |
| acc_addr | input | 3 | Register word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the transfer cycle |
| acc_err | output | 1 | Rejected transfer flag |
| pad_in | input | 32 | Sampled pad values |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check these rules on every cycle:
- Output pins never gain a pending bit.
- Written-one pending bits are zero after the write edge.
- A non-secure transfer leaves the mask unchanged, and a non-secure read of the mask returns zero.
- The error flag appears only during a transfer.
- `irq` needs a pending and enabled pin.

Only the bench's scenarios can show that the sensing follows the control bits group by group, that level mode re-arms after a clear, and that the reset values and unmapped addresses behave as stated. The bench shows these by comparing against its behavioural model on every clock.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt detection unit.
// Assumes a word-indexed register port with a 3-bit address.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd3;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd4;
endpackage

// File: rtl/gpio_irq_sense.sv
// Event detector: turns pad samples into per-pin event pulses.
// Each group of PINS/GROUPS pins shares one sense bit (ctrl[g]) and
// one polarity bit (ctrl[GROUPS+g]). Pins driven as outputs are gated off.
// Assumes pad_in is already synchronous to clk.
module gpio_irq_sense #(
    parameter int PINS   = 32,
    parameter int GROUPS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PINS-1:0]       pad_in,
    input  logic [PINS-1:0]       dir,
    input  logic [2*GROUPS-1:0]   ctrl,
    output logic [PINS-1:0]       evt
);
    localparam int GW = PINS / GROUPS;

    logic [PINS-1:0] prev_q;

    // Hold last cycle's pad sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pad_in;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [GW-1:0] cur, old, rise, fall, lvl, edg;
        assign cur  = pad_in[g*GW +: GW];
        assign old  = prev_q[g*GW +: GW];
        assign rise = cur & ~old;
        assign fall = ~cur & old;
        assign lvl  = ctrl[GROUPS+g] ? cur  : ~cur;
        assign edg  = ctrl[GROUPS+g] ? rise : fall;
        // Select sensing type and drop output pins.
        assign evt[g*GW +: GW] = (ctrl[g] ? edg : lvl) & ~dir[g*GW +: GW];
    end
endmodule

// File: rtl/gpio_irq_regs.sv
// Register file: decode, error detection, control/direction/enable/mask
// storage and the write-1-to-clear pending vector.
// Assumes single-cycle transfers; read data and error are combinational.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int GROUPS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic                  acc_nonsec,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [PINS-1:0]       acc_wdata,
    output logic [PINS-1:0]       acc_rdata,
    output logic                  acc_err,
    input  logic [PINS-1:0]       evt,
    output logic [2*GROUPS-1:0]   ctrl,
    output logic [PINS-1:0]       dir,
    output logic [PINS-1:0]       en,
    output logic [PINS-1:0]       mask,
    output logic [PINS-1:0]       pend
);
    localparam int CW = 2 * GROUPS;

    logic hit_ctrl, hit_dir, hit_en, hit_mask, hit_pend, known, sec_bad, wr_ok;
    logic [PINS-1:0] clr;

    assign hit_ctrl = (acc_addr == A_CTRL);
    assign hit_dir  = (acc_addr == A_DIR);
    assign hit_en   = (acc_addr == A_EN);
    assign hit_mask = (acc_addr == A_MASK);
    assign hit_pend = (acc_addr == A_PEND);
    assign known    = hit_ctrl | hit_dir | hit_en | hit_mask | hit_pend;
    assign sec_bad  = hit_mask & acc_nonsec;
    assign acc_err  = acc_valid & (~known | sec_bad);
    assign wr_ok    = acc_valid & acc_write & known & ~sec_bad;
    assign clr      = (wr_ok & hit_pend) ? acc_wdata : '0;

    // Configuration registers, updated by accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            dir  <= '0;
            en   <= '0;
            mask <= '1;
        end else if (wr_ok) begin
            if (hit_ctrl) ctrl <= acc_wdata[CW-1:0];
            if (hit_dir)  dir  <= acc_wdata;
            if (hit_en)   en   <= acc_wdata;
            if (hit_mask) mask <= acc_wdata;
        end
    end

    // Pending vector: events set, written ones clear, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend | evt) & ~clr;
    end

    // Read mux, zero outside read cycles and for rejected reads.
    always_comb begin
        acc_rdata = '0;
        if (acc_valid && !acc_write && !sec_bad) begin
            if (hit_ctrl) acc_rdata = {{(PINS-CW){1'b0}}, ctrl};
            if (hit_dir)  acc_rdata = dir;
            if (hit_en)   acc_rdata = en;
            if (hit_mask) acc_rdata = mask;
            if (hit_pend) acc_rdata = pend;
        end
    end

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_err && acc_addr == A_PEND)
        |=> ((pend & $past(acc_wdata)) == '0)); // R6
    AST_MASK_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_nonsec) |=> $stable(mask)); // R9
    AST_NS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_nonsec && acc_addr == A_MASK) |-> (acc_rdata == '0)); // R9
    AST_ERR_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_valid); // R11
endmodule

// File: rtl/gpio_irq_detect.sv
// Top of the GPIO interrupt detection unit: event sensing, register file
// and the final interrupt reduction.
// Assumes pad_in is synchronous and transfers last one cycle.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int GROUPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_nonsec,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PINS-1:0]   acc_wdata,
    output logic [PINS-1:0]   acc_rdata,
    output logic              acc_err,
    input  logic [PINS-1:0]   pad_in,
    output logic              irq
);
    logic [2*GROUPS-1:0] ctrl;
    logic [PINS-1:0]     dir, en, mask, pend, evt;

    gpio_irq_sense #(.PINS(PINS), .GROUPS(GROUPS)) u_sense (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dir(dir),
        .ctrl(ctrl), .evt(evt)
    );

    gpio_irq_regs #(.PINS(PINS), .GROUPS(GROUPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_nonsec(acc_nonsec), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .evt(evt), .ctrl(ctrl),
        .dir(dir), .en(en), .mask(mask), .pend(pend)
    );

    // Interrupt request: any pending, enabled, unmasked pin.
    assign irq = |(pend & en & ~mask);

    AST_OUT_PIN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & $past(dir)) == '0)); // R4
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & en) != '0)); // R7
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_nonsec = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0, pad_in = '0;
    logic [31:0] acc_rdata;
    logic        acc_err, irq;

    int checks = 0, fails = 0;
    string tag = "R8";

    // reference model state
    logic [3:0]  m_ctrl;
    logic [31:0] m_dir, m_en, m_mask, m_pend, m_prev;

    always #5 clk = ~clk;

    gpio_irq_detect u_gpio_irq_detect (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_nonsec(acc_nonsec), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .pad_in(pad_in), .irq(irq)
    );

    function automatic logic exp_err();
        return acc_valid && (acc_addr > 3'd4 || (acc_addr == 3'd3 && acc_nonsec));
    endfunction

    function automatic logic [31:0] exp_rdata();
        if (!acc_valid || acc_write) return 32'h0;
        case (acc_addr)
            3'd0: return {28'h0, m_ctrl};
            3'd1: return m_dir;
            3'd2: return m_en;
            3'd3: return acc_nonsec ? 32'h0 : m_mask;
            3'd4: return m_pend;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [31:0] evt, clr;
        if (!rst_n) begin
            m_ctrl = '0; m_dir = '0; m_en = '0; m_mask = '1; m_pend = '0; m_prev = '0;
            return;
        end
        for (int i = 0; i < 32; i++) begin
            int g = i / 16;
            logic edge_mode = m_ctrl[g];
            logic pol = m_ctrl[2+g];
            logic cur = pad_in[i];
            logic old = m_prev[i];
            if (m_dir[i]) evt[i] = 1'b0;
            else if (edge_mode) evt[i] = pol ? (cur && !old) : (!cur && old);
            else evt[i] = pol ? cur : !cur;
        end
        clr = '0;
        if (acc_valid && acc_write && !exp_err()) begin
            case (acc_addr)
                3'd0: m_ctrl = acc_wdata[3:0];
                3'd1: m_dir  = acc_wdata;
                3'd2: m_en   = acc_wdata;
                3'd3: m_mask = acc_wdata;
                3'd4: clr    = acc_wdata;
                default: ;
            endcase
        end
        m_pend = (m_pend | evt) & ~clr;
        m_prev = pad_in;
    endtask

    // One clock: compare outputs mid-cycle, then advance the model at the edge.
    task automatic cycle();
        #1;
        if (rst_n) begin
            check("irq (R7)", {31'h0, irq}, {31'h0, |(m_pend & m_en & ~m_mask)});
            check("acc_err (R11)", {31'h0, acc_err}, {31'h0, exp_err()});
            check("acc_rdata (R12)", acc_rdata, exp_rdata());
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic acc(logic wr, logic ns, logic [2:0] a, logic [31:0] d);
        acc_valid = 1'b1; acc_write = wr; acc_nonsec = ns; acc_addr = a; acc_wdata = d;
        cycle();
        acc_valid = 1'b0; acc_write = 1'b0; acc_nonsec = 1'b0; acc_wdata = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic read_all();
        for (int a = 0; a < 8; a++) acc(1'b0, 1'b0, 3'(a), 32'h0);
    endtask

    task automatic pads_random(int n, logic do_reads);
        for (int i = 0; i < n; i++) begin
            pad_in = $urandom;
            if (do_reads && (i % 3 == 0)) acc(1'b0, 1'b0, 3'd4, 0);
            else if (do_reads && (i % 7 == 1)) acc(1'b1, 1'b0, 3'd4, $urandom);
            else cycle();
        end
    endtask

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        pad_in = 32'h0000_0001;
        idle(3);
        rst_n = 1'b1;
        // R8: reset values
        tag = "R8"; read_all();

        // R7: interrupt follows pending, enable and mask
        tag = "R7";
        acc(1'b1, 1'b0, 3'd2, 32'h0000_00FF);
        acc(1'b1, 1'b0, 3'd3, 32'h0000_000F);
        idle(3);
        acc(1'b1, 1'b0, 3'd3, 32'h0000_0000);
        acc(1'b1, 1'b0, 3'd2, 32'hFFFF_FFFF);

        // R2/R1: group 0 edge rising, group 1 edge falling
        tag = "R2";
        acc(1'b1, 1'b0, 3'd0, 32'h0000_0007);
        acc(1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF);
        pads_random(40, 1'b1);
        // R1: group 0 edge falling, group 1 edge rising
        tag = "R1";
        acc(1'b1, 1'b0, 3'd0, 32'h0000_000B);
        acc(1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF);
        pads_random(40, 1'b1);

        // R3: group 0 level high, group 1 level low; clear does not hold
        tag = "R3";
        acc(1'b1, 1'b0, 3'd0, 32'h0000_0004);
        pad_in = 32'h0000_00FF;
        idle(2);
        acc(1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF);
        acc(1'b0, 1'b0, 3'd4, 0);
        acc(1'b0, 1'b0, 3'd4, 0);

        // R6: clear wins over a simultaneous level event
        tag = "R6";
        acc(1'b1, 1'b0, 3'd4, 32'h0000_000F);
        acc(1'b0, 1'b0, 3'd4, 0);
        // R5: zeros in the write leave bits alone
        tag = "R5";
        pad_in = 32'hFFFF_0000;
        acc(1'b1, 1'b0, 3'd0, 32'h0000_000F);
        idle(1);
        acc(1'b1, 1'b0, 3'd4, 32'h00F0_00F0);
        acc(1'b0, 1'b0, 3'd4, 0);

        // R4: upper pins as outputs never set pending
        tag = "R4";
        acc(1'b1, 1'b0, 3'd1, 32'hFFFF_0000);
        acc(1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF);
        acc(1'b1, 1'b0, 3'd0, 32'h0000_0000);
        pads_random(30, 1'b1);
        acc(1'b1, 1'b0, 3'd1, 32'h0000_0000);

        // R9: secure gating of the mask
        tag = "R9";
        acc(1'b1, 1'b1, 3'd3, 32'h1234_5678);
        acc(1'b0, 1'b1, 3'd3, 0);
        acc(1'b0, 1'b0, 3'd3, 0);
        acc(1'b1, 1'b0, 3'd3, 32'h0F0F_0F0F);
        acc(1'b0, 1'b0, 3'd3, 0);
        acc(1'b1, 1'b1, 3'd2, 32'h0000_FFFF);

        // R10: unmapped addresses
        tag = "R10";
        for (int a = 5; a < 8; a++) begin
            acc(1'b1, 1'b0, 3'(a), 32'hFFFF_FFFF);
            acc(1'b0, 1'b1, 3'(a), 0);
        end
        read_all();

        // R11/R12: mixed random traffic
        tag = "R11";
        for (int i = 0; i < 400; i++) begin
            pad_in = $urandom;
            if ($urandom % 2) acc(1'($urandom), 1'($urandom % 4 == 0), 3'($urandom), $urandom);
            else cycle();
        end
        tag = "R12"; read_all();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule